// File: doc/BRIEF.md
# Scratchpad Placement Table

This block records where each scratchpad block currently sits inside a hybrid cache, one that can lend individual cache lines to software-managed scratchpad storage. Every scratchpad block number owns one table entry holding a valid flag, a set index and a way. A memory pipeline presents a block number on the lookup port and gets the placement back in the same cycle. This lets the lookup run alongside address generation without adding a stage.

An adaptive mapping unit uses the update port to move a block off a heavily used set onto a lightly used one, or to release it. Each request is accepted or refused in the cycle it is presented. A refused request leaves the table untouched. After reset, the block fills every entry with a pseudo-random placement, one entry per clock. While it does so it raises a busy flag. With the default sizes (6-bit set field, two ways, 128 blocks) the seeding covers every line slot exactly once.

Top module: `spm_map_table`

## Requirements
- R1: While reset is high, and for exactly 128 clock edges after it is released, `busy` is 1. It then drops to 0 and stays 0 until the next reset.
- R2: Seeding places block i (0..126) at slot S_i. S_0 = 7'h01 and S_(k+1) = {S_k[5:0], S_k[6]^S_k[5]}. Block 127 is placed at slot 0. A slot s means set = s[6:1] and way = s[0]. All seeded entries are valid.
- R3: After seeding, no two blocks report the same set and way.
- R4: The lookup outputs (`lk_hit`, `lk_set`, `lk_way`) are combinational in `lk_blk` and reflect the table in the same cycle.
- R5: A lookup of an invalid entry returns `lk_hit`=0 with `lk_set`=0 and `lk_way`=0.
- R6: A valid update is accepted when the target slot is free or already belongs to the same block. The new placement is returned by lookups from the next cycle on, and the block's old slot becomes free.
- R7: A valid update whose target slot is held by another valid block is rejected, and both blocks keep their placements.
- R8: A valid update with a way value of 2 or 3 is rejected, and lookups never report a way above 1.
- R9: An update with `up_valid`=0 is accepted, clears the entry and frees its slot.
- R10: When an accepted update and a lookup name the same block in the same cycle, the lookup returns the new contents.
- R11: While `busy` is 1, every lookup misses and every update is rejected.
- R12: `up_ok` and `up_rej` are combinational and mutually exclusive. Exactly one of them is 1 when `up_req` is 1, and both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts seeding |
| busy | output | 1 | Seeding in progress |
| lk_blk | input | 7 | Block number to look up |
| lk_hit | output | 1 | Entry is valid |
| lk_set | output | 6 | Set index of the block, 0 on miss |
| lk_way | output | 2 | Way of the block, 0 on miss |
| up_req | input | 1 | Update request |
| up_blk | input | 7 | Block number to rewrite |
| up_valid | input | 1 | 1 places the block, 0 releases it |
| up_set | input | 6 | Target set |
| up_way | input | 2 | Target way |
| up_ok | output | 1 | Update accepted this cycle |
| up_rej | output | 1 | Update refused this cycle |

## Verification
Lookup results and the accept or refuse answer are combinational, so they are due in the cycle the inputs are applied. The bench drives inputs on the falling edge and samples them one nanosecond later, before the next rising edge. An accepted rewrite is due at the rising edge that follows the request. The bench therefore checks it with a fresh lookup on the next falling edge, except for the same-cycle bypass case, which it samples in the request cycle. The busy window is counted in falling edges from reset release, so the 128th sample is the first one due to show 0.

// File: rtl/spm_map_pkg.sv
package spm_map_pkg;
    localparam int BLK_W      = 7;
    localparam int SET_W      = 6;
    localparam int WAY_W      = 2;
    localparam int NUM_WAYS   = 2;
    localparam int WIDX_W     = $clog2(NUM_WAYS);
    localparam int SLOT_W     = SET_W + WIDX_W;
    localparam int NUM_BLOCKS = 1 << BLK_W;
    localparam int NUM_SLOTS  = 1 << SLOT_W;
    localparam logic [SLOT_W-1:0] LFSR_TAPS = SLOT_W'(7'h60);

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic              vld;
        logic [SET_W-1:0]  set;
        logic [WAY_W-1:0]  way;
    } map_entry_t;

    function automatic slot_t lfsr_step(input slot_t s);
        return {s[SLOT_W-2:0], ^(s & LFSR_TAPS)};
    endfunction

    function automatic slot_t slot_of(input logic [SET_W-1:0] set,
                                      input logic [WAY_W-1:0] way);
        return {set, way[WIDX_W-1:0]};
    endfunction

    function automatic map_entry_t entry_of(input slot_t s);
        map_entry_t e;
        e.vld = 1'b1;
        e.set = s[SLOT_W-1:WIDX_W];
        e.way = '0;
        e.way[WIDX_W-1:0] = s[WIDX_W-1:0];
        return e;
    endfunction
endpackage

// File: rtl/spm_map_seed.sv
module spm_map_seed
    import spm_map_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output logic  busy,
    output logic  seed_we,
    output blk_t  seed_blk,
    output slot_t seed_slot
);
    localparam blk_t LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    logic  busy_q;
    blk_t  idx_q;
    slot_t lfsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            lfsr_q <= SLOT_W'(1);
        end else if (busy_q) begin
            idx_q  <= idx_q + 1'b1;
            lfsr_q <= lfsr_step(lfsr_q);
            if (idx_q == LAST_BLK)
                busy_q <= 1'b0;
        end
    end

    assign busy      = busy_q;
    assign seed_we   = busy_q;
    assign seed_blk  = idx_q;
    assign seed_slot = (idx_q == LAST_BLK) ? '0 : lfsr_q;
endmodule

// File: rtl/spm_map_guard.sv
module spm_map_guard
    import spm_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             seed_we,
    input  slot_t            seed_slot,
    input  map_entry_t       cur,
    input  logic             req,
    input  logic             req_vld,
    input  logic [SET_W-1:0] req_set,
    input  logic [WAY_W-1:0] req_way,
    output logic             ok,
    output logic             rej
);
    logic [NUM_SLOTS-1:0] occ_q, occ_d;
    slot_t new_slot, old_slot;
    logic  way_legal, own_slot, allow;

    always_comb begin
        new_slot  = slot_of(req_set, req_way);
        old_slot  = slot_of(cur.set, cur.way);
        way_legal = {1'b0, req_way} < (WAY_W+1)'(NUM_WAYS);
        own_slot  = cur.vld && (old_slot == new_slot);
        allow     = !req_vld || (way_legal && (!occ_q[new_slot] || own_slot));
        ok        = req && !busy && allow;
        rej       = req && !ok;
    end

    always_comb begin
        occ_d = occ_q;
        if (seed_we) begin
            occ_d[seed_slot] = 1'b1;
        end else if (ok) begin
            if (cur.vld) occ_d[old_slot] = 1'b0;
            if (req_vld) occ_d[new_slot] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) occ_q <= '0;
        else     occ_q <= occ_d;
    end
endmodule

// File: rtl/spm_map_table.sv
module spm_map_table
    import spm_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic             busy,
    input  logic [BLK_W-1:0] lk_blk,
    output logic             lk_hit,
    output logic [SET_W-1:0] lk_set,
    output logic [WAY_W-1:0] lk_way,
    input  logic             up_req,
    input  logic [BLK_W-1:0] up_blk,
    input  logic             up_valid,
    input  logic [SET_W-1:0] up_set,
    input  logic [WAY_W-1:0] up_way,
    output logic             up_ok,
    output logic             up_rej
);
    map_entry_t tbl_q [NUM_BLOCKS];
    logic       seed_we;
    blk_t       seed_blk;
    slot_t      seed_slot;
    map_entry_t cur, new_ent, rd;

    spm_map_seed u_seed (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .seed_we   (seed_we),
        .seed_blk  (seed_blk),
        .seed_slot (seed_slot)
    );

    assign cur = tbl_q[up_blk];

    spm_map_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .seed_we   (seed_we),
        .seed_slot (seed_slot),
        .cur       (cur),
        .req       (up_req),
        .req_vld   (up_valid),
        .req_set   (up_set),
        .req_way   (up_way),
        .ok        (up_ok),
        .rej       (up_rej)
    );

    always_comb begin
        if (up_valid) new_ent = '{vld: 1'b1, set: up_set, way: up_way};
        else          new_ent = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BLOCKS; i++) tbl_q[i] <= '0;
        end else if (seed_we) begin
            tbl_q[seed_blk] <= entry_of(seed_slot);
        end else if (up_ok) begin
            tbl_q[up_blk] <= new_ent;
        end
    end

    always_comb begin
        rd = tbl_q[lk_blk];
        if (up_ok && (up_blk == lk_blk)) rd = new_ent;
        if (busy || !rd.vld)             rd = '0;
    end

    assign lk_hit = rd.vld;
    assign lk_set = rd.set;
    assign lk_way = rd.way;
endmodule

// File: rtl/spm_map_table_chk.sv
module spm_map_table_chk
    import spm_map_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [BLK_W-1:0] lk_blk,
    input logic             lk_hit,
    input logic [SET_W-1:0] lk_set,
    input logic [WAY_W-1:0] lk_way,
    input logic             up_req,
    input logic [BLK_W-1:0] up_blk,
    input logic             up_valid,
    input logic [SET_W-1:0] up_set,
    input logic [WAY_W-1:0] up_way,
    input logic             up_ok,
    input logic             up_rej
);
    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(up_ok && up_rej));                                                    // R12
    AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !up_req |-> (!up_ok && !up_rej));                                       // R12
    AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (rst)
        (busy && up_req) |-> up_rej);                                           // R11
    AST_BUSY_MISSES: assert property (@(posedge clk) disable iff (rst)
        busy |-> !lk_hit);                                                      // R11
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_set == '0 && lk_way == '0));                            // R5
    AST_WAY_LEGAL: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ({1'b0, lk_way} < (WAY_W+1)'(NUM_WAYS)));                    // R8
    AST_BUSY_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy);                                                       // R1
    AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (up_ok && up_blk == lk_blk) |-> (lk_hit == up_valid));                  // R10
    AST_COMMIT_SEEN: assert property (@(posedge clk) disable iff (rst)
        (up_ok && up_valid) |=>
        ((lk_blk != $past(up_blk)) || (up_req && up_blk == lk_blk) ||
         (lk_hit && lk_set == $past(up_set) && lk_way == $past(up_way))));     // R6
endmodule

bind spm_map_table spm_map_table_chk u_chk (.*);

// File: tb/spm_map_table_test.sv
`timescale 1ns/1ps
module spm_map_table_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       busy;
    logic [6:0] lk_blk;
    logic       lk_hit;
    logic [5:0] lk_set;
    logic [1:0] lk_way;
    logic       up_req;
    logic [6:0] up_blk;
    logic       up_valid;
    logic [5:0] up_set;
    logic [1:0] up_way;
    logic       up_ok;
    logic       up_rej;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;
    int ev [128];
    int esl[128];

    always #5 clk = ~clk;

    spm_map_table uut (.*);

    task automatic check(input string rq, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic int expect_look(input int b);
        if (ev[b] == 0) return 0;
        return (1 << 8) | ((esl[b] >> 1) << 2) | (esl[b] & 1);
    endfunction

    function automatic int got_look();
        return (int'(lk_hit) << 8) | (int'(lk_set) << 2) | int'(lk_way);
    endfunction

    task automatic look(input int b, input string rq);
        @(negedge clk);
        lk_blk = 7'(b);
        #1;
        check(rq, got_look(), expect_look(b));
    endtask

    task automatic upd(input int b, input bit v, input int set, input int way,
                       input bit exp_ok, input string rq);
        @(negedge clk);
        up_req = 1; up_blk = 7'(b); up_valid = v;
        up_set = 6'(set); up_way = 2'(way);
        #1;
        check(rq, {30'd0, up_ok, up_rej}, {30'd0, exp_ok, !exp_ok});
        @(negedge clk);
        up_req = 0;
        if (exp_ok) begin
            ev[b]  = v;
            esl[b] = v ? (set * 2 + (way & 1)) : 0;
        end
    endtask

    task automatic t_reset_busy();
        int n = 0;
        rst = 1; up_req = 0; lk_blk = 0; up_blk = 0; up_valid = 0;
        up_set = 0; up_way = 0;
        repeat (2) @(posedge clk);
        #1 check("R1 busy in reset", busy, 1);
        @(negedge clk);
        rst = 0;
        up_req = 1; up_blk = 7'd3; up_valid = 0; lk_blk = 7'd0;
        #1;
        check("R11 lookup misses while busy", got_look(), 0);
        check("R11 update refused while busy", {up_ok, up_rej}, 2'b01);
        while (busy && n < 400) begin
            @(negedge clk);
            up_req = 0;
            n++;
        end
        check("R1 busy window length", n, 128);
        repeat (3) @(negedge clk);
        check("R1 busy stays low", busy, 0);
    endtask

    task automatic t_seed();
        bit seen[128];
        int dup = 0;
        for (int i = 0; i < 128; i++) seen[i] = 0;
        for (int b = 0; b < 128; b++) begin
            look(b, "R2 seeded placement");
            if (lk_hit) begin
                int s = int'(lk_set) * 2 + int'(lk_way[0]);
                if (seen[s]) dup++;
                seen[s] = 1;
            end
        end
        check("R3 distinct seeded slots", dup, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        up_req = 0; up_blk = 7'd5; up_valid = 1;
        #1;
        check("R12 no answer without request", {up_ok, up_rej}, 2'b00);
        lk_blk = 7'd40;
        #1;
        check("R4 same-cycle lookup", got_look(), expect_look(40));
    endtask

    task automatic t_collide();
        upd(5, 1, esl[9] >> 1, esl[9] & 1, 0, "R7 collision refused");
        look(5, "R7 mover unchanged");
        look(9, "R7 holder unchanged");
    endtask

    task automatic t_release();
        upd(9, 0, 0, 0, 1, "R9 release accepted");
        look(9, "R5 released entry misses");
    endtask

    task automatic t_bad_way();
        upd(5, 1, esl_free_set, 2 + esl_free_way, 0, "R8 way 2/3 refused");
        look(5, "R8 entry unchanged");
    endtask

    int esl_free_set, esl_free_way;

    task automatic t_move();
        int old5 = esl[5];
        upd(5, 1, esl_free_set, esl_free_way, 1, "R6 move to free slot");
        look(5, "R6 new placement visible");
        upd(7, 1, old5 >> 1, old5 & 1, 1, "R6 vacated slot reusable");
        look(7, "R6 second move visible");
        upd(7, 1, esl[7] >> 1, esl[7] & 1, 1, "R6 own slot accepted");
        look(7, "R6 own slot kept");
    endtask

    task automatic t_bypass();
        int old20 = esl[20];
        @(negedge clk);
        up_req = 1; up_blk = 7'd20; up_valid = 0; up_set = 0; up_way = 0;
        lk_blk = 7'd20;
        #1;
        check("R10 bypass of release", got_look(), 0);
        lk_blk = 7'd21;
        #1;
        check("R10 other block unaffected", got_look(), expect_look(21));
        @(negedge clk);
        ev[20] = 0; esl[20] = 0;
        up_blk = 7'd20; up_valid = 1;
        up_set = 6'(old20 >> 1); up_way = 2'(old20 & 1);
        lk_blk = 7'd20;
        #1;
        check("R10 bypass of placement", got_look(),
              (1 << 8) | ((old20 >> 1) << 2) | (old20 & 1));
        @(negedge clk);
        up_req = 0;
        ev[20] = 1; esl[20] = old20;
        look(20, "R10 placement kept after bypass");
    endtask

    initial begin
        int s = 1;
        for (int i = 0; i < 127; i++) begin
            ev[i] = 1; esl[i] = s;
            s = ((s << 1) & 7'h7f) | (((s >> 6) ^ (s >> 5)) & 1);
        end
        ev[127] = 1; esl[127] = 0;
        t_reset_busy();
        t_seed();
        t_idle();
        t_collide();
        esl_free_set = esl[9] >> 1;
        esl_free_way = esl[9] & 1;
        t_release();
        t_bad_way();
        t_move();
        t_bypass();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule